// File: doc/BRIEF.md
# Parallel-load serial-out shift register with clock enable

This block is a shift register of parameterised width (default 8) with positions Q0 to Q(N-1). On each rising clock edge where the active-low enable is low, it does one of two things. When the active-low load select is low, it captures a whole parallel word. When the load select is high, it shifts: Q0 takes the serial input and each other position takes the value of its lower neighbour. The top position Q(N-1) is the serial output. Wiring it to the serial input of a second copy builds a longer converter.

The enable works as a synchronous qualifier on one free-running clock. It stands in for an OR-gated clock. The clear input is active low and asynchronous. It forces every position to zero at once and overrides all other inputs. Its release passes through a short synchroniser, so the first edges after reset are well defined. The whole register is also driven onto a read-only port for observation.

Top module: `pisoshift`

## Requirements
- R1: While `clr_n` is low, `state_out` is all zeros without waiting for a clock edge, and load, shift and enable have no effect.
- R2: After `clr_n` rises, the first two rising clock edges leave the register at zero whatever the other inputs are. The third edge is the first one that can load or shift.
- R3: At a rising edge with `ce_n` high, the register keeps its value, whatever `load_n`, `ser_in` and `par_in` are.
- R4: At a rising edge with `ce_n` low and `load_n` low, the register takes `par_in`, with bit i of `par_in` going to position Qi (bit i of `state_out`).
- R5: At a rising edge with `ce_n` low and `load_n` high, bit 0 takes `ser_in` and bit i takes the old bit i-1, so data moves from the Q0 end toward the top end.
- R6: `ser_out` always equals the top bit of `state_out`.
- R7: Two copies, with the first's `ser_out` wired to the second's `ser_in`, act as one shift register of twice the width when both shift on the same edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| ce_n | input | 1 | Clock enable, active low |
| load_n | input | 1 | Parallel load select, active low; high selects shift |
| ser_in | input | 1 | Serial data into position Q0 |
| par_in | input | WIDTH | Parallel data word; bit i loads Qi |
| ser_out | output | 1 | Top register position, serial or cascade output |
| state_out | output | WIDTH | Full register contents, read-only |

## Verification
A behavioural model predicts both registers of a two-stage chain, and the bench compares them with the model after every edge. The loaded words include alternating and single-bit patterns, which show whether any bit lands in the wrong position. A serial stream of mixed ones and zeros, clocked across the chain boundary, shows the shift direction and the cascade link. Enable-high cycles with changing load, serial and parallel inputs show that the register holds. A clear asserted mid-shift, with a load pending, shows that the clear overrides everything. The loads offered in the two edges after release show the synchronised start.

// File: rtl/pisoshift.sv
module pisoshift #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ce_n,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] state_out
);

  logic [SYNC_STAGES-1:0] rel_q;
  logic                   run;
  logic [WIDTH-1:0]       q;

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) rel_q <= '0;
    else        rel_q <= {rel_q[SYNC_STAGES-2:0], 1'b1};

  assign run = rel_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n)             q <= '0;
    else if (run && !ce_n)  q <= load_n ? {q[WIDTH-2:0], ser_in} : par_in;

  assign state_out = q;
  assign ser_out   = q[WIDTH-1];

  // R2
  start_quiet_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !run |=> state_out == '0);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (run && ce_n) |=> $stable(state_out));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (run && !ce_n && !load_n) |=> state_out == $past(par_in));

  // R5
  shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (run && !ce_n && load_n) |=> state_out == {$past(state_out[WIDTH-2:0]), $past(ser_in)});

  // R6
  top_bit_chk: assert property (@(posedge clk) disable iff (!clr_n)
    ser_out == state_out[WIDTH-1]);

endmodule

// File: tb/test_pisoshift.sv
module test_pisoshift;
  localparam int W = 8;
  localparam logic [W-1:0] MASK = 8'h5A;

  logic clk = 0;
  logic clr_n = 0, ce_n = 1, load_n = 1, ser_in = 0;
  logic [W-1:0] par_a = '0, par_b = '0;
  logic so_a, so_b;
  logic [W-1:0] st_a, st_b;
  logic [W-1:0] m1 = '0, m2 = '0;
  int since_rel = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pisoshift #(.WIDTH(W)) i_pisoshift (
    .clk(clk), .clr_n(clr_n), .ce_n(ce_n), .load_n(load_n), .ser_in(ser_in),
    .par_in(par_a), .ser_out(so_a), .state_out(st_a));

  pisoshift #(.WIDTH(W)) i_pisoshift_b (
    .clk(clk), .clr_n(clr_n), .ce_n(ce_n), .load_n(load_n), .ser_in(so_a),
    .par_in(par_b), .ser_out(so_b), .state_out(st_b));

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    check(st_a === m1, req, st_a, m1);
    check(st_b === m2, {req, "/R7"}, st_b, m2);
    check(so_a === st_a[W-1] && so_b === st_b[W-1], "R6", {6'd0, so_b, so_a}, {6'd0, st_b[W-1], st_a[W-1]});
  endtask

  task automatic step(input logic ce, input logic ld, input logic si, input logic [W-1:0] pa, input string req);
    logic old_top;
    ce_n = ce; load_n = ld; ser_in = si; par_a = pa; par_b = pa ^ MASK;
    @(posedge clk);
    if (clr_n) begin
      if (since_rel >= 2 && !ce) begin
        old_top = m1[W-1];
        if (!ld) begin m1 = pa; m2 = pa ^ MASK; end
        else begin m2 = {m2[W-2:0], old_top}; m1 = {m1[W-2:0], si}; end
      end
      if (since_rel < 2) since_rel++;
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic release_clear();
    @(negedge clk);
    clr_n = 1; since_rel = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] stream;
    #1;
    @(negedge clk);
    compare("R1 reset");
    release_clear();
    // R2: two loads right after release are ignored
    step(0, 0, 1, 8'hFF, "R2");
    step(0, 0, 1, 8'hFF, "R2");
    // R4: position-sensitive loads
    step(0, 0, 0, 8'hA5, "R4");
    step(0, 0, 0, 8'h01, "R4");
    step(0, 0, 0, 8'h80, "R4");
    // R3: hold with everything else toggling
    step(1, 0, 1, 8'h3C, "R3");
    step(1, 1, 1, 8'hC3, "R3");
    step(1, 1, 0, 8'hFF, "R3");
    // R5 and R7: shift a mixed stream across the chain boundary
    step(0, 0, 0, 8'hC9, "R4");
    stream = 16'b1011_0010_1110_0101;
    for (int i = 0; i < 16; i++) begin
      step(0, 1, stream[i], 8'h00, "R5");
      if (i == 7) step(1, 1, 1, 8'hFF, "R3");
    end
    step(0, 0, 0, 8'h6E, "R4");
    step(0, 1, 1, 8'h00, "R5");
    step(0, 1, 0, 8'h00, "R5");
    // R1: clear mid-shift, asynchronous and overriding a pending load
    #5 clr_n = 0;
    #1;
    m1 = '0; m2 = '0; since_rel = 0;
    check(st_a === '0 && st_b === '0, "R1 async", st_a | st_b, '0);
    @(negedge clk);
    step(0, 0, 1, 8'hFF, "R1");
    step(0, 1, 1, 8'hFF, "R1");
    release_clear();
    step(0, 1, 1, 8'hFF, "R2");
    step(0, 0, 1, 8'h77, "R2");
    step(0, 1, 1, 8'h00, "R5");
    step(0, 0, 0, 8'h96, "R4");
    for (int i = 0; i < 10; i++) step(0, 1, i[0], 8'h00, "R5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule